// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects five interrupt sources and a bus-hold request on behalf of a small CPU core, picks the most urgent eligible source and presents it to the core with a fixed 16-bit service address. The sources differ in how they are gated. The power-fail input (TRAP) cannot be blocked by software. It fires on a rising edge, but only while its level is still high. Three restart inputs (R75, R65, R55) are gated by a global enable flag and by their own mask bits. R75 is caught by a sticky edge latch. R65 and R55 follow their input level. The general request (INTR) is gated only by the global enable flag. When INTR is acknowledged, the block pulses an active-low acknowledge strobe so that an external device can supply its own vector.

Software reaches the block through three command strobes from the core's instruction decoder. `cmd_ei_i` and `cmd_di_i` set and clear the global enable flag. `cmd_sim_i` applies an 8-bit set-mask byte, which can load the mask bits, clear the R75 latch and update a one-bit serial output latch. A status byte (`rim_o`) is always driven so that the core can capture it when it runs a read-mask instruction.

The controller is a four-state machine. IDLE waits for work. HOLD grants the bus. REQ presents a captured source and waits for the core's acknowledge. INTA drives the device-acknowledge strobe for one cycle. The transitions are as follows:
- IDLE goes to HOLD when `hold_i` is high, and otherwise goes to REQ when any source is eligible.
- HOLD returns to IDLE when `hold_i` falls.
- REQ goes to HOLD when `hold_i` is high. Otherwise, on `ack_i`, it goes to INTA for INTR and to IDLE for every other source.
- INTA always returns to IDLE.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several sources are eligible, the one presented follows the fixed order TRAP > R75 > R65 > R55 > INTR. `src_o` encodes the source as 0 none, 1 TRAP, 2 R75, 3 R65, 4 R55, 5 INTR.
- R2: While `irq_o` is high, `vec_o` is 0x0024 for TRAP, 0x003C for R75, 0x0034 for R65, 0x002C for R55 and 0x0000 for INTR.
- R3: TRAP is serviced whatever the global enable flag and the mask bits hold.
- R4: TRAP is eligible only when its edge latch is set and `trap_i` is still high. The latch is cleared only by reset or by acknowledging TRAP, so a held-high `trap_i` does not fire again after its acknowledge.
- R5: When `hold_i` is high in IDLE, HOLD is granted (`hlda_o` high, `irq_o` low) even if TRAP arrives in the same cycle. A pending TRAP is presented on the second clock edge after `hold_i` falls.
- R6: R75, R65 and R55 need the global enable flag set and their mask bit clear. INTR needs only the flag. `cmd_ei_i` sets the flag, `cmd_di_i` clears it, and `cmd_di_i` wins when both are high.
- R7: Set-mask bits 2, 1 and 0 are the masks of R75, R65 and R55 (1 = masked). They load only when bit 3 is 1. After reset all three are masked.
- R8: The R75 latch sets on a rising edge of `r75_i`, whether or not R75 is masked or the flag is clear. Set-mask bit 4 = 1 clears the latch, and a clear wins over a new edge in the same cycle.
- R9: A set-mask byte with bit 6 = 1 copies bit 7 into `sod_o`. With bit 6 = 0, `sod_o` keeps its value.
- R10: `rim_o` bit 7 is `sid_i`, bit 6 is the R75 latch, bit 5 is `r65_i`, bit 4 is `r55_i`, bit 3 is the enable flag and bits 2..0 are the masks.
- R11: Acknowledging any source other than TRAP clears the enable flag, and acknowledging TRAP leaves the flag unchanged. Acknowledging TRAP or R75 clears that source's latch.
- R12: Acknowledging INTR drives `inta_n_o` low for exactly one cycle, starting on the acknowledge edge.
- R13: Reset leaves `irq_o` low, `hlda_o` low, `inta_n_o` high, `sod_o` low, the flag clear and all masks set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable request, edge and level |
| r75_i | input | 1 | Restart 7.5 request, rising edge |
| r65_i | input | 1 | Restart 6.5 request, level |
| r55_i | input | 1 | Restart 5.5 request, level |
| intr_i | input | 1 | General request, level |
| hold_i | input | 1 | Bus-hold request |
| sid_i | input | 1 | Serial input pin, reported in the status byte |
| cmd_ei_i | input | 1 | Enable-interrupts strobe |
| cmd_di_i | input | 1 | Disable-interrupts strobe |
| cmd_sim_i | input | 1 | Set-mask strobe |
| sim_data_i | input | 8 | Set-mask byte |
| ack_i | input | 1 | Core accepts the presented interrupt |
| irq_o | output | 1 | Interrupt presented to the core |
| src_o | output | 3 | Presented source code |
| vec_o | output | VEC_W | Service address of the presented source |
| inta_n_o | output | 1 | Active-low device-acknowledge strobe |
| hlda_o | output | 1 | Bus-hold grant |
| sod_o | output | 1 | Serial output latch |
| rim_o | output | 8 | Read-mask status byte |

## Verification
A table of patterns applies many sources at once in different combinations:
- All five sources together, then with each higher source removed in turn. This shows whether the order of the priority chain is right.
- The same sets with the enable flag cleared. This separates TRAP from the gated sources.
- Partial and full masks with the flag set. This shows whether each mask bit gates exactly its own input, and whether INTR ignores the masks.

Directed sequences cover the following:
- HOLD racing TRAP in the same cycle.
- A TRAP pulse that falls before the bus is released, which must not fire.
- A masked R75 edge that stays latched until a set-mask clear.
- The enable-flag effect of each kind of acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC = 5;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_INTR = 3'd5
    } src_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HOLD,
        S_REQ,
        S_INTA
    } state_e;

    // set-mask byte bit positions
    localparam int SIM_MSK_EN = 3;
    localparam int SIM_CLR75  = 4;
    localparam int SIM_SO_EN  = 6;
    localparam int SIM_SO_DAT = 7;

    localparam logic [15:0] VEC_TRAP = 16'h0024;
    localparam logic [15:0] VEC_R75  = 16'h003C;
    localparam logic [15:0] VEC_R65  = 16'h0034;
    localparam logic [15:0] VEC_R55  = 16'h002C;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic lat_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            lat_o  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (clr_i)
                lat_o <= 1'b0;
            else if (lvl_i && !prev_q)
                lat_o <= 1'b1;
        end
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !lat_o); // R8

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && $rose(lvl_i)) |=> lat_o); // R8

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req_i,   // bit 0 is the most urgent
    output src_e         win_o
);

    always_comb begin
        win_o = SRC_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i])
                win_o = src_e'(3'(i + 1));
        end
    end

endmodule

// File: rtl/irq_vec_rom.sv
module irq_vec_rom
    import irq_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic [2:0]       src_i,
    output logic [VEC_W-1:0] vec_o
);

    always_comb begin
        unique case (src_i)
            SRC_TRAP: vec_o = VEC_W'(VEC_TRAP);
            SRC_R75:  vec_o = VEC_W'(VEC_R75);
            SRC_R65:  vec_o = VEC_W'(VEC_R65);
            SRC_R55:  vec_o = VEC_W'(VEC_R55);
            default:  vec_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_i,
    input  logic             r75_i,
    input  logic             r65_i,
    input  logic             r55_i,
    input  logic             intr_i,
    input  logic             hold_i,
    input  logic             sid_i,
    input  logic             cmd_ei_i,
    input  logic             cmd_di_i,
    input  logic             cmd_sim_i,
    input  logic [7:0]       sim_data_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [2:0]       src_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             inta_n_o,
    output logic             hlda_o,
    output logic             sod_o,
    output logic [7:0]       rim_o
);

    localparam int MASK_W = 3;

    state_e              state_q, state_d;
    src_e                cur_q, win;
    logic                ie_q;
    logic [MASK_W-1:0]   mask_q;
    logic                sod_q;
    logic                trap_lat, r75_lat;
    logic [NSRC-1:0]     req;
    logic                ack_fire, clr_trap, clr_r75;
    logic                sim_unused;

    assign sim_unused = sim_data_i[5];

    assign ack_fire = (state_q == S_REQ) && ack_i && !hold_i;
    assign clr_trap = ack_fire && (cur_q == SRC_TRAP);
    assign clr_r75  = (cmd_sim_i && sim_data_i[SIM_CLR75]) ||
                      (ack_fire && (cur_q == SRC_R75));

    irq_edge_latch u_trap_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (trap_i),
        .clr_i (clr_trap),
        .lat_o (trap_lat)
    );

    irq_edge_latch u_r75_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (r75_i),
        .clr_i (clr_r75),
        .lat_o (r75_lat)
    );

    // eligibility, index 0 most urgent
    assign req[0] = trap_lat & trap_i;
    assign req[1] = ie_q & ~mask_q[2] & r75_lat;
    assign req[2] = ie_q & ~mask_q[1] & r65_i;
    assign req[3] = ie_q & ~mask_q[0] & r55_i;
    assign req[4] = ie_q & intr_i;

    irq_arbiter #(.N(NSRC)) u_arb (
        .req_i (req),
        .win_o (win)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (hold_i)
                    state_d = S_HOLD;
                else if (win != SRC_NONE)
                    state_d = S_REQ;
            end
            S_HOLD: begin
                if (!hold_i)
                    state_d = S_IDLE;
            end
            S_REQ: begin
                if (hold_i)
                    state_d = S_HOLD;
                else if (ack_i)
                    state_d = (cur_q == SRC_INTR) ? S_INTA : S_IDLE;
            end
            S_INTA:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and captured source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= SRC_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && !hold_i && win != SRC_NONE)
                cur_q <= win;
        end
    end

    // enable flag, masks, serial output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
            sod_q  <= 1'b0;
        end else begin
            if (cmd_di_i || (ack_fire && cur_q != SRC_TRAP))
                ie_q <= 1'b0;
            else if (cmd_ei_i)
                ie_q <= 1'b1;
            if (cmd_sim_i && sim_data_i[SIM_MSK_EN])
                mask_q <= sim_data_i[MASK_W-1:0];
            if (cmd_sim_i && sim_data_i[SIM_SO_EN])
                sod_q <= sim_data_i[SIM_SO_DAT];
        end
    end

    // outputs
    always_comb begin
        irq_o    = (state_q == S_REQ);
        src_o    = irq_o ? cur_q : SRC_NONE;
        hlda_o   = (state_q == S_HOLD);
        inta_n_o = (state_q != S_INTA);
        sod_o    = sod_q;
        rim_o    = {sid_i, r75_lat, r65_i, r55_i, ie_q, mask_q};
    end

    irq_vec_rom #(.VEC_W(VEC_W)) u_vec (
        .src_i (src_o),
        .vec_o (vec_o)
    );

    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !hold_i && req[0]) |=> (src_o == SRC_TRAP)); // R1

    AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && src_o == SRC_TRAP) |-> $past(trap_i)); // R4

    AST_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hlda_o && irq_o)); // R5

    AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && hold_i) |=> hlda_o); // R5

    AST_GATED_R65: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && src_o == SRC_R65) |-> $past(ie_q && !mask_q[1])); // R6

    AST_IE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i && !hold_i && src_o != SRC_TRAP) |=> !rim_o[3]); // R11

    AST_INTA_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |=> inta_n_o); // R12

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_i = 0, r75_i = 0, r65_i = 0, r55_i = 0, intr_i = 0;
    logic        hold_i = 0, sid_i = 0, ack_i = 0;
    logic        cmd_ei_i = 0, cmd_di_i = 0, cmd_sim_i = 0;
    logic [7:0]  sim_data_i = 8'h00;
    logic        irq_o, inta_n_o, hlda_o, sod_o;
    logic [2:0]  src_o;
    logic [15:0] vec_o;
    logic [7:0]  rim_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .r75_i(r75_i),
        .r65_i(r65_i), .r55_i(r55_i), .intr_i(intr_i), .hold_i(hold_i),
        .sid_i(sid_i), .cmd_ei_i(cmd_ei_i), .cmd_di_i(cmd_di_i),
        .cmd_sim_i(cmd_sim_i), .sim_data_i(sim_data_i), .ack_i(ack_i),
        .irq_o(irq_o), .src_o(src_o), .vec_o(vec_o), .inta_n_o(inta_n_o),
        .hlda_o(hlda_o), .sod_o(sod_o), .rim_o(rim_o)
    );

    // {ie, mask[2:0], trap, r75, r65, r55, intr, expected src[2:0]}
    localparam int NV = 11;
    localparam logic [11:0] TBL [NV] = '{
        12'b1_000_11111_001,
        12'b1_000_01111_010,
        12'b1_000_00111_011,
        12'b1_000_00011_100,
        12'b1_000_00001_101,
        12'b0_000_11111_001,
        12'b0_000_01111_000,
        12'b1_100_01100_011,
        12'b1_110_01110_100,
        12'b1_111_01111_101,
        12'b1_111_10000_001
    };

    function automatic logic [15:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd1:    return 16'h0024;
            3'd2:    return 16'h003C;
            3'd3:    return 16'h0034;
            3'd4:    return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic sim(input logic [7:0] d);
        cmd_sim_i = 1'b1;
        sim_data_i = d;
        tick();
        cmd_sim_i = 1'b0;
    endtask

    task automatic set_ie(input logic en);
        cmd_ei_i = en;
        cmd_di_i = !en;
        tick();
        cmd_ei_i = 1'b0;
        cmd_di_i = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        chk("R13 irq", irq_o, 0);
        chk("R13 hlda", hlda_o, 0);
        chk("R13 inta_n", inta_n_o, 1);
        chk("R13 sod", sod_o, 0);
        chk("R13 rim", rim_o, 8'h07);

        // table walk: R1 R2 R3 R6 R12
        for (int v = 0; v < NV; v++) begin
            logic [11:0] e;
            e = TBL[v];
            cmd_ei_i = e[11];
            cmd_di_i = !e[11];
            cmd_sim_i = 1'b1;
            sim_data_i = {5'b00011, e[10:8]};
            tick();
            cmd_ei_i = 0; cmd_di_i = 0; cmd_sim_i = 0;
            trap_i = e[7]; r75_i = e[6];
            tick();
            r75_i = 0; r65_i = e[5]; r55_i = e[4]; intr_i = e[3];
            tick();
            chk($sformatf("R1/R3/R6 irq row%0d", v), irq_o, (e[2:0] != 0));
            chk($sformatf("R1 src row%0d", v), src_o, e[2:0]);
            if (e[2:0] != 0)
                chk($sformatf("R2 vec row%0d", v), vec_o, exp_vec(e[2:0]));
            ack_i = (e[2:0] != 0);
            cmd_di_i = 1; cmd_sim_i = 1; sim_data_i = 8'h10;
            trap_i = 0; r65_i = 0; r55_i = 0; intr_i = 0;
            tick();
            ack_i = 0; cmd_di_i = 0; cmd_sim_i = 0;
            if (e[2:0] == 3'd5)
                chk($sformatf("R12 inta low row%0d", v), inta_n_o, 0);
            chk($sformatf("R1 irq dropped row%0d", v), irq_o, 0);
            tick();
            chk($sformatf("R12 inta high row%0d", v), inta_n_o, 1);
        end

        // R5 hold wins over trap in the same cycle
        hold_i = 1; trap_i = 1;
        tick();
        chk("R5 hlda", hlda_o, 1);
        chk("R5 irq held off", irq_o, 0);
        tick();
        chk("R5 irq still off", irq_o, 0);
        hold_i = 0;
        tick();
        chk("R5 hlda released", hlda_o, 0);
        chk("R5 not yet", irq_o, 0);
        tick();
        chk("R5 trap after hold", src_o, 1);
        ack_i = 1; trap_i = 0;
        tick();
        ack_i = 0;

        // R4 trap pulse gone before service does not fire
        hold_i = 1; trap_i = 1;
        tick();
        trap_i = 0;
        tick();
        hold_i = 0;
        tick(); tick(); tick();
        chk("R4 no level no trap", irq_o, 0);
        trap_i = 1;
        tick();
        chk("R4 latch plus level", src_o, 1);
        ack_i = 1;
        tick();
        ack_i = 0;
        chk("R4 cleared by ack", irq_o, 0);
        tick();
        chk("R4 held level no refire", irq_o, 0);
        trap_i = 0;

        // R11 trap ack keeps the enable flag
        set_ie(1);
        trap_i = 1;
        tick(); tick();
        chk("R11 trap presented", src_o, 1);
        ack_i = 1;
        tick();
        ack_i = 0; trap_i = 0;
        chk("R11 flag kept after trap", rim_o[3], 1);

        // R11 R75 ack clears latch and flag
        sim(8'h08);
        r75_i = 1;
        tick();
        r75_i = 0;
        tick();
        chk("R11 r75 presented", src_o, 2);
        chk("R8 r75 latched", rim_o[6], 1);
        ack_i = 1;
        tick();
        ack_i = 0;
        chk("R11 r75 latch cleared", rim_o[6], 0);
        chk("R11 flag cleared", rim_o[3], 0);

        // R8 sticky latch while disabled, R7 mask load enable
        r75_i = 1;
        tick();
        r75_i = 0;
        tick(); tick();
        chk("R8 no irq while disabled", irq_o, 0);
        chk("R8 latch sticky", rim_o[6], 1);
        sim(8'h10);
        chk("R8 set-mask clear", rim_o[6], 0);
        chk("R7 masks kept without bit3", rim_o[2:0], 3'b000);
        sim(8'h0F);
        chk("R7 masks loaded", rim_o[2:0], 3'b111);
        sim(8'h05);
        chk("R7 masks ignore without bit3", rim_o[2:0], 3'b111);

        // R6 enable and disable
        set_ie(1);
        chk("R6 EI sets flag", rim_o[3], 1);
        cmd_ei_i = 1; cmd_di_i = 1;
        tick();
        cmd_ei_i = 0; cmd_di_i = 0;
        chk("R6 DI wins", rim_o[3], 0);

        // R9 serial output latch
        sim(8'hC0);
        chk("R9 sod set", sod_o, 1);
        sim(8'h80);
        chk("R9 sod held without bit6", sod_o, 1);
        sim(8'h40);
        chk("R9 sod cleared", sod_o, 0);

        // R10 status byte with masked level inputs
        sid_i = 1; r65_i = 1; r55_i = 1;
        tick();
        chk("R10 rim byte", rim_o, 8'hB7);
        chk("R10 masked levels silent", irq_o, 0);
        sid_i = 0; r65_i = 0; r55_i = 0;

        // R13 reset mid-run
        sim(8'hC8);
        set_ie(1);
        rst_n = 0;
        tick();
        rst_n = 1;
        chk("R13 sod after reset", sod_o, 0);
        chk("R13 rim after reset", rim_o, 8'h07);
        chk("R13 inta_n after reset", inta_n_o, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule